// File: doc/BRIEF.md
# Function Reset Sequencer

This block performs a full function-level reset of one target function. It takes the reset over from host software. A caller puts a function number on the command interface and pulses start. The engine holds busy high, runs three phases strictly one after another and then pulses done together with a result code. All traffic goes through one register master port that allows a single outstanding access. A space-select bit picks either the function's mailbox window or its PCIe configuration space. The function number travels with every access, so the target side resolves the per-function base address.

The first phase requests the pre-reset of internal queue state by writing 1 to the pre-reset status word. It then polls that word until hardware clears bit 0. The second phase polls the Transaction Pending flag of the PCIe Device Status register so that outstanding traffic can drain. This poll gives up after a programmable number of cycles and still lets the sequence continue. The last phase sets the initiate-function-reset bit of Device Control through a read-modify-write. Back-to-back polls are spaced by a programmable number of idle cycles. The pre-reset poll has its own fixed limit; if that limit runs out, the sequence aborts before it ever touches configuration space.

Top module: `frst_seq`

## Requirements
- R1: The phases run pre-reset, then quiesce, then Device Control update. No configuration-space access (reg_cfg_space=1) is issued until a pre-reset status read has returned bit 0 = 0 in the current sequence.
- R2: The first access of a sequence is a mailbox-space write (reg_cfg_space=0, reg_wr=1) to offset 0x100 with data 0x00000001 and reg_func equal to the accepted cmd_func.
- R3: After that write, the engine reads mailbox offset 0x100 repeatedly and leaves the phase only on a read whose bit 0 is 0.
- R4: A phase timer restarts when each poll phase begins. If a pre-reset read returns bit 0 = 1 while the timer is at or above PRE_TIMEOUT, the sequence ends with cmd_status = 2 and no configuration-space access.
- R5: The quiesce phase reads the configuration dword at CAP_OFS+8 (default 0x078). Bit 21 of that dword is Transaction Pending (bit 5 of Device Status). The phase ends on a read with bit 21 = 0.
- R6: If a quiesce read returns bit 21 = 1 while the timer is at or above cfg_quiesce_limit, quiesce_tmo is set and the sequence continues to the Device Control update. It ends with cmd_status = 1. quiesce_tmo stays set until the next accepted start. With a limit of 0, exactly one quiesce read is issued.
- R7: The final phase reads the dword at CAP_OFS+8 and then writes it back as {16'h0000, low16 | 16'h8000}. Bit 15 (initiate reset) is set, the other Device Control bits are preserved, and zero is written to the write-one-to-clear status half.
- R8: After a poll read that returns busy, reg_req stays low for exactly cfg_poll_gap+1 cycles before the next poll read.
- R9: A request holds reg_req, reg_wr, reg_cfg_space, reg_addr and reg_wdata steady until the cycle reg_ack is high. Only one access is outstanding.
- R10: cmd_start is accepted only while cmd_busy is low. While busy, start pulses are ignored and reg_func keeps the accepted function.
- R11: cmd_done is high for exactly one cycle at the end of a sequence. cmd_status is valid in that cycle (0 = clean, 1 = quiesce timeout, 2 = pre-reset abort), and cmd_busy is low in the next cycle.
- R12: After reset, cmd_busy, cmd_done, reg_req and quiesce_tmo are low and cmd_status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start request, sampled while idle |
| cmd_func | input | FN_W | Target function number |
| cmd_busy | output | 1 | Sequence in progress |
| cmd_done | output | 1 | One-cycle end-of-sequence pulse |
| cmd_status | output | 2 | Result code, valid with cmd_done |
| quiesce_tmo | output | 1 | Sticky quiesce timeout flag |
| cfg_quiesce_limit | input | TMR_W | Quiesce give-up threshold in cycles |
| cfg_poll_gap | input | GAP_W | Idle cycles between polls, minus one |
| reg_req | output | 1 | Access request, held until ack |
| reg_wr | output | 1 | 1 = write, 0 = read |
| reg_cfg_space | output | 1 | 0 = mailbox window, 1 = configuration space |
| reg_func | output | FN_W | Function the access targets |
| reg_addr | output | 12 | Byte offset within the selected space |
| reg_wdata | output | 32 | Write data |
| reg_ack | input | 1 | Access complete; read data valid |
| reg_rdata | input | 32 | Read data |

## Verification
On every cycle the assertions check the port rules and the ordering that can be seen from port activity. These are: no configuration access before the pre-reset clears, no configuration access at all on an abort, requests held until acknowledged, the exact idle spacing after a busy poll, a one-cycle done pulse, and the flag staying set until the next accepted start. The bench scenarios cover the parts that depend on target contents and on counting. These include the number of polls for a given target behaviour, the bit-15 merge that preserves the other Device Control bits, timeouts at a zero and a nonzero limit, an abort under a target that never clears, and start pulses that must be ignored mid-sequence.

// File: rtl/frst_pkg.sv
package frst_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE_WR, S_PRE_RD, S_PRE_GAP,
    S_Q_RD, S_Q_GAP, S_CTL_RD, S_CTL_WR, S_FIN
  } frst_state_e;

  typedef enum logic [1:0] {
    FRST_OK     = 2'd0,
    FRST_QTMO   = 2'd1,
    FRST_PRETMO = 2'd2
  } frst_status_e;

  localparam logic [11:0] PRE_STAT_OFS = 12'h100;
  localparam int          TP_BIT       = 21;  // Device Status bit 5 in the upper half
  localparam logic [15:0] INIT_RST     = 16'h8000;

  function automatic logic pre_pending(input logic [31:0] d);
    return d[0];
  endfunction

  function automatic logic tx_pending(input logic [31:0] d);
    return d[TP_BIT];
  endfunction

  // status half written as zero so its write-one-to-clear bits are untouched
  function automatic logic [31:0] devctl_merge(input logic [31:0] d);
    return {16'h0000, d[15:0] | INIT_RST};
  endfunction

  function automatic logic [11:0] devctl_addr(input logic [11:0] cap);
    return cap + 12'h008;
  endfunction

endpackage

// File: rtl/frst_tmr.sv
module frst_tmr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (cnt != '1)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/frst_gap.sv
module frst_gap #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  input  logic         run,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= val;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/frst_ctrl.sv
module frst_ctrl
  import frst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        ack,
  input  logic        pre_bit,
  input  logic        tp_bit,
  input  logic        tmo,
  input  logic        gap_zero,
  output frst_state_e state,
  output logic        accept,
  output logic        tmr_clr,
  output logic        gap_load,
  output logic        poll_retry,
  output logic        pre_clear,
  output logic        pre_abort,
  output logic        qto_hit
);
  frst_state_e nxt;

  always_comb begin
    nxt        = state;
    accept     = 1'b0;
    tmr_clr    = 1'b0;
    gap_load   = 1'b0;
    poll_retry = 1'b0;
    pre_clear  = 1'b0;
    pre_abort  = 1'b0;
    qto_hit    = 1'b0;
    case (state)
      S_IDLE:    if (start) begin nxt = S_PRE_WR; accept = 1'b1; end
      S_PRE_WR:  if (ack) begin nxt = S_PRE_RD; tmr_clr = 1'b1; end
      S_PRE_RD:
        if (ack) begin
          if (!pre_bit) begin
            nxt = S_Q_RD; tmr_clr = 1'b1; pre_clear = 1'b1;
          end else if (tmo) begin
            nxt = S_FIN; pre_abort = 1'b1;
          end else begin
            nxt = S_PRE_GAP; gap_load = 1'b1; poll_retry = 1'b1;
          end
        end
      S_PRE_GAP: if (gap_zero) nxt = S_PRE_RD;
      S_Q_RD:
        if (ack) begin
          if (!tp_bit) begin
            nxt = S_CTL_RD;
          end else if (tmo) begin
            nxt = S_CTL_RD; qto_hit = 1'b1;
          end else begin
            nxt = S_Q_GAP; gap_load = 1'b1; poll_retry = 1'b1;
          end
        end
      S_Q_GAP:   if (gap_zero) nxt = S_Q_RD;
      S_CTL_RD:  if (ack) nxt = S_CTL_WR;
      S_CTL_WR:  if (ack) nxt = S_FIN;
      S_FIN:     nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/frst_seq.sv
module frst_seq
  import frst_pkg::*;
#(
  parameter int          FN_W        = 8,
  parameter int          TMR_W       = 16,
  parameter int          GAP_W       = 8,
  parameter int          PRE_TIMEOUT = 4096,
  parameter logic [11:0] CAP_OFS     = 12'h070
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [FN_W-1:0]  cmd_func,
  output logic             cmd_busy,
  output logic             cmd_done,
  output logic [1:0]       cmd_status,
  output logic             quiesce_tmo,
  input  logic [TMR_W-1:0] cfg_quiesce_limit,
  input  logic [GAP_W-1:0] cfg_poll_gap,
  output logic             reg_req,
  output logic             reg_wr,
  output logic             reg_cfg_space,
  output logic [FN_W-1:0]  reg_func,
  output logic [11:0]      reg_addr,
  output logic [31:0]      reg_wdata,
  input  logic             reg_ack,
  input  logic [31:0]      reg_rdata
);
  localparam logic [TMR_W-1:0] PRE_LIM  = TMR_W'(PRE_TIMEOUT);
  localparam logic [11:0]      CTL_ADDR = devctl_addr(CAP_OFS);

  frst_state_e  state;
  frst_status_e status_q;
  logic [FN_W-1:0]  func_q;
  logic [31:0]      ctl_q;
  logic [TMR_W-1:0] tmr_cnt, tmr_lim;
  logic accept, tmr_clr, gap_load, poll_retry, pre_clear, pre_abort, qto_hit;
  logic gap_zero, gap_run, in_pre, tmo, qto_q;

  assign in_pre  = state inside {S_PRE_WR, S_PRE_RD, S_PRE_GAP};
  assign tmr_lim = in_pre ? PRE_LIM : cfg_quiesce_limit;
  assign tmo     = (tmr_cnt >= tmr_lim);
  assign gap_run = state inside {S_PRE_GAP, S_Q_GAP};

  frst_ctrl u_ctrl (
    .clk, .rst_n,
    .start      (cmd_start),
    .ack        (reg_ack),
    .pre_bit    (pre_pending(reg_rdata)),
    .tp_bit     (tx_pending(reg_rdata)),
    .tmo        (tmo),
    .gap_zero   (gap_zero),
    .state      (state),
    .accept     (accept),
    .tmr_clr    (tmr_clr),
    .gap_load   (gap_load),
    .poll_retry (poll_retry),
    .pre_clear  (pre_clear),
    .pre_abort  (pre_abort),
    .qto_hit    (qto_hit)
  );

  frst_tmr #(.W(TMR_W)) u_tmr (
    .clk, .rst_n, .clr(tmr_clr), .cnt(tmr_cnt)
  );

  frst_gap #(.W(GAP_W)) u_gap (
    .clk, .rst_n, .load(gap_load), .val(cfg_poll_gap), .run(gap_run), .zero(gap_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q   <= '0;
      ctl_q    <= '0;
      status_q <= FRST_OK;
      qto_q    <= 1'b0;
    end else begin
      if (accept) begin
        func_q   <= cmd_func;
        status_q <= FRST_OK;
        qto_q    <= 1'b0;
      end
      if (qto_hit) begin
        qto_q    <= 1'b1;
        status_q <= FRST_QTMO;
      end
      if (pre_abort) status_q <= FRST_PRETMO;
      if (state == S_CTL_RD && reg_ack) ctl_q <= reg_rdata;
    end
  end

  assign cmd_busy      = (state != S_IDLE);
  assign cmd_done      = (state == S_FIN);
  assign cmd_status    = status_q;
  assign quiesce_tmo   = qto_q;
  assign reg_req       = state inside {S_PRE_WR, S_PRE_RD, S_Q_RD, S_CTL_RD, S_CTL_WR};
  assign reg_wr        = state inside {S_PRE_WR, S_CTL_WR};
  assign reg_cfg_space = state inside {S_Q_RD, S_CTL_RD, S_CTL_WR};
  assign reg_func      = func_q;
  assign reg_addr      = reg_cfg_space ? CTL_ADDR : PRE_STAT_OFS;
  assign reg_wdata     = (state == S_CTL_WR) ? devctl_merge(ctl_q) :
                         (state == S_PRE_WR) ? 32'h0000_0001 : 32'h0;
endmodule

// File: rtl/frst_seq_chk.sv
module frst_seq_chk #(
  parameter int FN_W  = 8,
  parameter int GAP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_start,
  input logic             cmd_busy,
  input logic             cmd_done,
  input logic [1:0]       cmd_status,
  input logic             quiesce_tmo,
  input logic [GAP_W-1:0] cfg_poll_gap,
  input logic             reg_req,
  input logic             reg_wr,
  input logic             reg_cfg_space,
  input logic [FN_W-1:0]  reg_func,
  input logic [11:0]      reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             reg_ack,
  input logic             poll_retry,
  input logic             pre_clear
);
  logic pre_ok, cfg_seen, gap_arm;
  logic [GAP_W:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_ok   <= 1'b0;
      cfg_seen <= 1'b0;
      gap_arm  <= 1'b0;
      idle_cnt <= '0;
    end else begin
      if (cmd_start && !cmd_busy) begin
        pre_ok   <= 1'b0;
        cfg_seen <= 1'b0;
      end
      if (pre_clear) pre_ok <= 1'b1;
      if (reg_req && reg_cfg_space) cfg_seen <= 1'b1;
      if (poll_retry) begin
        gap_arm  <= 1'b1;
        idle_cnt <= '0;
      end else if (gap_arm && !reg_req) begin
        idle_cnt <= idle_cnt + 1'b1;
      end else if (gap_arm && reg_req) begin
        gap_arm <= 1'b0;
      end
    end
  end

  assert_cfg_after_pre_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && reg_cfg_space |-> pre_ok);

  assert_abort_no_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && cmd_status == 2'd2 |-> !cfg_seen);

  assert_qto_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && cmd_status == 2'd1 |-> quiesce_tmo);

  assert_qto_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(quiesce_tmo) |-> $past(cmd_start && !cmd_busy));

  assert_gap_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gap_arm && reg_req |-> idle_cnt == ({1'b0, cfg_poll_gap} + 1'b1));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_wr) && $stable(reg_cfg_space)
      && $stable(reg_addr) && $stable(reg_wdata));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_busy |-> !reg_req);

  assert_func_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_busy && $past(cmd_busy) |-> $stable(reg_func));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done && !cmd_busy);
endmodule

bind frst_seq frst_seq_chk #(.FN_W(FN_W), .GAP_W(GAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_busy(cmd_busy),
  .cmd_done(cmd_done), .cmd_status(cmd_status), .quiesce_tmo(quiesce_tmo),
  .cfg_poll_gap(cfg_poll_gap), .reg_req(reg_req), .reg_wr(reg_wr),
  .reg_cfg_space(reg_cfg_space), .reg_func(reg_func), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_ack(reg_ack), .poll_retry(poll_retry),
  .pre_clear(pre_clear)
);

// File: tb/frst_seq_tb.sv
`timescale 1ns/1ps
module frst_seq_tb;
  localparam int FN_W = 8, TMR_W = 16, GAP_W = 8, PRE_TO = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 1'b0;
  logic [FN_W-1:0] cmd_func = '0;
  logic cmd_busy, cmd_done, quiesce_tmo;
  logic [1:0] cmd_status;
  logic [TMR_W-1:0] cfg_quiesce_limit = 16'd1000;
  logic [GAP_W-1:0] cfg_poll_gap = 8'd2;
  logic reg_req, reg_wr, reg_cfg_space;
  logic [FN_W-1:0] reg_func;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic reg_ack = 1'b0;
  logic [31:0] reg_rdata = '0;

  always #2.5 clk = ~clk;

  frst_seq #(.FN_W(FN_W), .TMR_W(TMR_W), .GAP_W(GAP_W), .PRE_TIMEOUT(PRE_TO),
             .CAP_OFS(12'h070)) u_dut (
    .clk, .rst_n, .cmd_start, .cmd_func, .cmd_busy, .cmd_done, .cmd_status,
    .quiesce_tmo, .cfg_quiesce_limit, .cfg_poll_gap, .reg_req, .reg_wr,
    .reg_cfg_space, .reg_func, .reg_addr, .reg_wdata, .reg_ack, .reg_rdata);

  int n_chk = 0, n_fail = 0;

  // target model and monitors
  logic clr = 1'b0;
  int   pre_busy_cfg = 0, tp_busy_cfg = 0, lat_cfg = 0;
  int   pre_left, tp_left, wcnt;
  logic mb_bit;
  logic [15:0] devctl;
  int   n_pre_wr, n_pre_rd, n_cfg_rd, n_cfg_wr, cfg_early, bad_addr, hold_err;
  int   n_done, done_long, busy_after_done, idle_run, idle_min, idle_max;
  logic [31:0] last_pre_wdata, last_cfg_wdata;
  logic [FN_W-1:0] last_func;
  logic [1:0] done_status;
  logic done_qto, prev_req, prev_ack, prev_done;
  logic [11:0] prev_addr;
  logic prev_wr;

  always @(posedge clk) begin
    if (clr) begin
      pre_left <= pre_busy_cfg; tp_left <= tp_busy_cfg; wcnt <= 0;
      mb_bit <= 1'b0; devctl <= 16'h2C5F;
      n_pre_wr <= 0; n_pre_rd <= 0; n_cfg_rd <= 0; n_cfg_wr <= 0;
      cfg_early <= 0; bad_addr <= 0; hold_err <= 0; n_done <= 0;
      done_long <= 0; busy_after_done <= 0; idle_run <= 0;
      idle_min <= 1000; idle_max <= 0; reg_ack <= 1'b0;
      last_pre_wdata <= '0; last_cfg_wdata <= '0; last_func <= '0;
      done_status <= '0; done_qto <= 1'b0;
    end else begin
      reg_ack <= 1'b0;
      if (reg_req && !reg_ack) begin
        if (wcnt < lat_cfg) wcnt <= wcnt + 1;
        else begin
          wcnt <= 0; reg_ack <= 1'b1; last_func <= reg_func;
          if (!reg_cfg_space) begin
            if (reg_addr != 12'h100) bad_addr <= bad_addr + 1;
            if (reg_wr) begin
              n_pre_wr <= n_pre_wr + 1; last_pre_wdata <= reg_wdata; mb_bit <= reg_wdata[0];
            end else begin
              n_pre_rd <= n_pre_rd + 1;
              if (mb_bit && pre_left == 0) begin mb_bit <= 1'b0; reg_rdata <= 32'h0; end
              else if (mb_bit) begin pre_left <= pre_left - 1; reg_rdata <= 32'h1; end
              else reg_rdata <= 32'h0;
            end
          end else begin
            if (reg_addr != 12'h078) bad_addr <= bad_addr + 1;
            if (mb_bit) cfg_early <= cfg_early + 1;
            if (reg_wr) begin
              n_cfg_wr <= n_cfg_wr + 1; last_cfg_wdata <= reg_wdata; devctl <= reg_wdata[15:0];
            end else begin
              n_cfg_rd <= n_cfg_rd + 1;
              if (tp_left > 0) tp_left <= tp_left - 1;
              reg_rdata <= {(tp_left > 0) ? 16'h0024 : 16'h0004, devctl};
            end
          end
        end
      end
      if (reg_req && prev_req && !prev_ack && (reg_addr != prev_addr || reg_wr != prev_wr))
        hold_err <= hold_err + 1;
      if (cmd_done) begin n_done <= n_done + 1; done_status <= cmd_status; done_qto <= quiesce_tmo; end
      if (prev_done && cmd_done) done_long <= done_long + 1;
      if (prev_done && cmd_busy) busy_after_done <= busy_after_done + 1;
      if (cmd_busy && !reg_req) idle_run <= idle_run + 1;
      else if (reg_req) begin
        if (idle_run > 0) begin
          if (idle_run < idle_min) idle_min <= idle_run;
          if (idle_run > idle_max) idle_max <= idle_run;
        end
        idle_run <= 0;
      end else idle_run <= 0;
    end
    prev_req <= reg_req; prev_ack <= reg_ack; prev_addr <= reg_addr;
    prev_wr <= reg_wr; prev_done <= cmd_done;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic prep(input int gap, input int qlim, input int preb, input int tpb, input int lat);
    @(negedge clk);
    cfg_poll_gap = 8'(gap); cfg_quiesce_limit = 16'(qlim);
    pre_busy_cfg = preb; tp_busy_cfg = tpb; lat_cfg = lat;
    clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic run_seq(input logic [FN_W-1:0] f);
    @(negedge clk) begin cmd_start = 1'b1; cmd_func = f; end
    @(negedge clk) cmd_start = 1'b0;
    for (int g = 0; g < 50000 && cmd_busy; g++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R12 busy", 32'(cmd_busy), 0);
    chk("R12 done", 32'(cmd_done), 0);
    chk("R12 req", 32'(reg_req), 0);
    chk("R12 qto", 32'(quiesce_tmo), 0);
    chk("R12 status", 32'(cmd_status), 0);
  endtask

  task automatic t_nominal();
    prep(2, 1000, 2, 3, 2);
    run_seq(8'h15);
    chk("R2 pre write count", n_pre_wr, 1);
    chk("R2 pre write data", last_pre_wdata, 32'h1);
    chk("R2 target function", 32'(last_func), 32'h15);
    chk("R3 pre poll reads", n_pre_rd, 3);
    chk("R1 no cfg access before pre clear", cfg_early, 0);
    chk("R5 cfg reads (4 quiesce + 1 control)", n_cfg_rd, 5);
    chk("R5 R2 address offsets", bad_addr, 0);
    chk("R7 control write count", n_cfg_wr, 1);
    chk("R7 control write data", last_cfg_wdata, 32'h0000_AC5F);
    chk("R11 status clean", 32'(done_status), 0);
    chk("R11 one done", n_done, 1);
    chk("R11 done width", done_long, 0);
    chk("R11 busy after done", busy_after_done, 0);
    chk("R6 qto clear", 32'(quiesce_tmo), 0);
    chk("R8 min gap", idle_min, 3);
    chk("R8 max gap", idle_max, 3);
    chk("R9 hold while waiting", hold_err, 0);
  endtask

  task automatic t_gap0();
    prep(0, 1000, 1, 2, 0);
    run_seq(8'h02);
    chk("R8 gap0 min", idle_min, 1);
    chk("R8 gap0 max", idle_max, 1);
    chk("R3 pre reads gap0", n_pre_rd, 2);
  endtask

  task automatic t_qtmo_zero();
    prep(1, 0, 0, 1000000, 1);
    run_seq(8'h33);
    chk("R6 single quiesce read + control read", n_cfg_rd, 2);
    chk("R6 status quiesce timeout", 32'(done_status), 1);
    chk("R6 flag at done", 32'(done_qto), 1);
    chk("R6 control still written", last_cfg_wdata, 32'h0000_AC5F);
    repeat (10) @(negedge clk);
    chk("R6 flag sticky", 32'(quiesce_tmo), 1);
  endtask

  task automatic t_qtmo_mid();
    prep(3, 20, 0, 1000000, 1);
    run_seq(8'h34);
    chk("R6 status after timed quiesce", 32'(done_status), 1);
    chk("R6 control written after timeout", n_cfg_wr, 1);
    prep(1, 1000, 0, 0, 0);
    run_seq(8'h35);
    chk("R6 flag cleared by new start", 32'(quiesce_tmo), 0);
    chk("R6 status clean again", 32'(done_status), 0);
  endtask

  task automatic t_pre_abort();
    prep(2, 1000, 1000000, 0, 1);
    run_seq(8'h40);
    chk("R4 status abort", 32'(done_status), 2);
    chk("R4 no cfg reads", n_cfg_rd, 0);
    chk("R4 no cfg writes", n_cfg_wr, 0);
    chk("R4 qto untouched", 32'(quiesce_tmo), 0);
    chk("R3 repeated polls", 32'(n_pre_rd > 10), 1);
  endtask

  task automatic t_busy_ignore();
    prep(2, 1000, 3, 2, 1);
    @(negedge clk) begin cmd_start = 1'b1; cmd_func = 8'hA1; end
    @(negedge clk) cmd_start = 1'b0;
    repeat (4) @(negedge clk);
    cmd_start = 1'b1; cmd_func = 8'hB2;
    @(negedge clk) cmd_start = 1'b0;
    repeat (9) @(negedge clk);
    cmd_start = 1'b1;
    @(negedge clk) cmd_start = 1'b0;
    for (int g = 0; g < 50000 && cmd_busy; g++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk("R10 single done", n_done, 1);
    chk("R10 single pre write", n_pre_wr, 1);
    chk("R10 function kept", 32'(last_func), 32'hA1);
    chk("R10 idle after", 32'(cmd_busy), 0);
  endtask

  logic finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nominal();
    t_gap0();
    t_qtmo_zero();
    t_qtmo_mid();
    t_pre_abort();
    t_busy_ignore();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (R1..): actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule